// File: doc/BRIEF.md
# Random Word Register Front-End

This block is the register-facing side of a random number generator. An entropy
source outside the block delivers 32-bit conditioned words on a valid strobe.
When software has switched the generator on, the block gathers these words into a
small output buffer. Once the buffer is full it raises a ready flag, and software
then drains the buffer through a data register. The same register file also holds
the configuration, a noise-source control word and a health-test control word.
These carry no behaviour of their own and are only stored and read back.

Error handling drives most of the design. A seed fault from the source raises two
status flags. One latches the event; the other shows that the fault is still
present. While the fault is present, no new words are taken in, and any word
still sitting in the buffer reads as zero. Software recovers with a conditional
reset. It writes the reset bit high and then low. The bit keeps reading high
while an internal reset runs for a fixed number of cycles, and during that time
the buffer is emptied. At the end of the reset both seed flags clear. A seed
fault that the source repaired by itself sets only the latched flag. A clock
fault sets its own latched flag unless it is masked.

Top module: `rngfe_top`

## Requirements
- R1: After reset, every register reads zero: control at 0x00, status at 0x04, data at 0x08, noise control at 0x0C and health-test control at 0x10.
- R2: The writable control bits are: enable at bit 2, clock-fault mask at bit 5, configuration bits 25:8 and conditional reset at bit 30. All other control bits read zero, so writing all ones reads back 0x43FFFF24.
- R3: The noise control register keeps only its low 18 bits. The health-test register keeps all 32 bits.
- R4: Status bit 0 (ready) sets once four valid words have been taken in while enabled. The data register then returns those words oldest first, one per read. Ready clears after the fourth read. A data read while ready is clear returns zero and removes nothing.
- R5: No word is taken in while enable is clear or while ready is set.
- R6: A seed fault while enabled sets status bit 6 and status bit 2. While bit 2 is set, no word is taken in.
- R7: While status bit 2 is set, a data read returns zero but still removes a buffered word.
- R8: Writing 1 then 0 to control bit 30 keeps bit 30 reading 1 for exactly 16 cycles after the 0 is written. When it clears, status bits 2 and 6 are also cleared. Words buffered before the reset are discarded, so ready reads 0.
- R9: A self-repaired seed fault sets status bit 6 and leaves bit 2 clear. Writing 0 to bit 6 clears it; writing 1 has no effect.
- R10: A clock fault sets status bit 5 when control bit 5 is 0. It is ignored when control bit 5 is 1. Writing 0 to status bit 5 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a data read removes a word |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as reg_rd |
| ent_valid | input | 1 | Entropy word strobe |
| ent_word | input | 32 | Conditioned entropy word |
| seed_fault | input | 1 | Seed fault pulse from the source |
| seed_autofix | input | 1 | Self-repaired seed fault pulse |
| clk_fault | input | 1 | Clock fault pulse |

## Verification
The hardest case to reach is the late seed fault. The fault must arrive while the
buffer is ready and only partly drained, so the zero reads can be told apart from
an empty buffer. The stimulus fills the buffer and reads two words. It then pulses
the fault and reads the remaining two words, expecting zeros. After that it
checks that ready has dropped and that new words are refused until a conditional
reset has finished counting. A second reset is issued while the buffer is full, to
show that the flush discards the buffered words.

// File: rtl/rngfe_pkg.sv
package rngfe_pkg;
   localparam int unsigned REG_W  = 32;
   localparam int unsigned ADDR_W = 5;

   localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_NOISE = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_HTEST = 5'h10;

   localparam int unsigned CB_EN     = 2;
   localparam int unsigned CB_CKMASK = 5;
   localparam int unsigned CB_CRST   = 30;

   localparam int unsigned SB_RDY   = 0;
   localparam int unsigned SB_SECUR = 2;
   localparam int unsigned SB_CKERR = 5;
   localparam int unsigned SB_SEERR = 6;

   // plain storage bits of control (conditional reset is held separately)
   localparam logic [REG_W-1:0] CTRL_STORE_MASK = 32'h03FF_FF24;

   typedef struct packed {
      logic seed_latched;
      logic clk_latched;
      logic seed_now;
   } flags_t;
endpackage

// File: rtl/rngfe_fifo.sv
module rngfe_fifo #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         push,
   input  logic [DW-1:0]                din,
   input  logic                         pop,
   output logic [DW-1:0]                head,
   output logic                         ready,
   output logic [$clog2(DEPTH+1)-1:0]   level
);
   localparam int unsigned PW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rngfe_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;
   logic          rdy_q;
   logic          do_push, do_pop;

   assign do_push = push && !rdy_q && !flush;
   assign do_pop  = pop && rdy_q && !flush;

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         cnt   <= '0;
         rdy_q <= 1'b0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         cnt   <= '0;
         rdy_q <= 1'b0;
      end else begin
         if (do_push) begin
            wptr <= wptr + PW'(1);
            cnt  <= cnt + CW'(1);
            if (cnt == CW'(DEPTH - 1)) rdy_q <= 1'b1;
         end
         if (do_pop) begin
            rptr <= rptr + PW'(1);
            cnt  <= cnt - CW'(1);
            if (cnt == CW'(1)) rdy_q <= 1'b0;
         end
      end
   end

   assign head  = mem[rptr];
   assign ready = rdy_q;
   assign level = cnt;

   assert_ready_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (level != '0));
   assert_ready_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (level == CW'(DEPTH)));
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));
endmodule

// File: rtl/rngfe_guard.sv
module rngfe_guard #(
   parameter bit          HAS_CRST    = 1'b1,
   parameter int unsigned CRST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic ck_mask,
   input  logic seed_fault,
   input  logic seed_autofix,
   input  logic clk_fault,
   input  logic ctrl_we,
   input  logic ctrl_crst_bit,
   input  logic stat_we,
   input  logic stat_seed_bit,
   input  logic stat_clk_bit,
   output rngfe_pkg::flags_t flags,
   output logic crst_busy
);
   localparam int unsigned CNTW = $clog2(CRST_CYCLES + 1);

   if (CRST_CYCLES < 2) begin : g_bad_cycles
      $error("rngfe_guard: CRST_CYCLES must be at least 2");
   end

   logic seed_evt, auto_evt, seis_q, secs_q, ceis_q;

   assign seed_evt = enable && seed_fault && !crst_busy;
   assign auto_evt = enable && seed_autofix && !crst_busy && !seed_fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ceis_q <= 1'b0;
      else if (clk_fault && !ck_mask) ceis_q <= 1'b1;
      else if (stat_we && !stat_clk_bit) ceis_q <= 1'b0;
   end

   if (HAS_CRST) begin : g_crst
      logic            crst_q;
      logic [CNTW-1:0] cnt;
      logic            done;

      assign done = (cnt == CNTW'(1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            crst_q <= 1'b0;
            cnt    <= '0;
         end else if (cnt != '0) begin
            cnt <= cnt - CNTW'(1);
            if (done) crst_q <= 1'b0;
         end else if (ctrl_we) begin
            if (ctrl_crst_bit) crst_q <= 1'b1;
            else if (crst_q) cnt <= CNTW'(CRST_CYCLES);
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seis_q <= 1'b0;
            secs_q <= 1'b0;
         end else if (done) begin
            seis_q <= 1'b0;
            secs_q <= 1'b0;
         end else if (seed_evt) begin
            seis_q <= 1'b1;
            secs_q <= 1'b1;
         end else if (auto_evt) begin
            seis_q <= 1'b1;
         end else if (stat_we && !stat_seed_bit) begin
            seis_q <= 1'b0;
         end
      end

      assign crst_busy = crst_q;

      assert_crst_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(crst_busy) |-> (!secs_q && !seis_q));
   end else begin : g_swclear
      logic unused_crst;
      assign unused_crst = ctrl_we ^ ctrl_crst_bit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seis_q <= 1'b0;
            secs_q <= 1'b0;
         end else if (seed_evt) begin
            seis_q <= 1'b1;
            secs_q <= 1'b1;
         end else if (auto_evt) begin
            seis_q <= 1'b1;
         end else if (stat_we && !stat_seed_bit) begin
            seis_q <= 1'b0;
            secs_q <= 1'b0;
         end
      end

      assign crst_busy = 1'b0;
   end

   assign flags.seed_latched = seis_q;
   assign flags.seed_now     = secs_q;
   assign flags.clk_latched  = ceis_q;

   assert_seed_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && seed_fault && !crst_busy) |=> (flags.seed_latched && flags.seed_now));
   assert_autofix_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && seed_autofix && !seed_fault && !crst_busy && !flags.seed_now)
         |=> (flags.seed_latched && !flags.seed_now));
   assert_clk_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_fault && !ck_mask) |=> flags.clk_latched);
endmodule

// File: rtl/rngfe_top.sv
module rngfe_top #(
   parameter int unsigned DEPTH       = 4,
   parameter int unsigned NOISE_W     = 18,
   parameter bit          HAS_CRST    = 1'b1,
   parameter int unsigned CRST_CYCLES = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [4:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        ent_valid,
   input  logic [31:0] ent_word,
   input  logic        seed_fault,
   input  logic        seed_autofix,
   input  logic        clk_fault
);
   import rngfe_pkg::*;

   localparam int unsigned LVW = $clog2(DEPTH + 1);

   if (NOISE_W < 1 || NOISE_W > REG_W) begin : g_bad_noise
      $error("rngfe_top: NOISE_W must lie in 1..32");
   end

   logic [REG_W-1:0]   ctrl_q;
   logic [NOISE_W-1:0] noise_q;
   logic [REG_W-1:0]   htest_q;

   logic       we_ctrl, we_stat, we_noise, we_htest, rd_data;
   flags_t     flags;
   logic       crst_busy;
   logic       fifo_ready, fifo_push;
   logic [31:0] fifo_head;
   logic [LVW-1:0] fifo_level;

   assign we_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
   assign we_stat  = reg_wr && (reg_addr == OFS_STAT);
   assign we_noise = reg_wr && (reg_addr == OFS_NOISE);
   assign we_htest = reg_wr && (reg_addr == OFS_HTEST);
   assign rd_data  = reg_rd && (reg_addr == OFS_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         noise_q <= '0;
         htest_q <= '0;
      end else begin
         if (we_ctrl)  ctrl_q  <= reg_wdata & CTRL_STORE_MASK;
         if (we_noise) noise_q <= reg_wdata[NOISE_W-1:0];
         if (we_htest) htest_q <= reg_wdata;
      end
   end

   rngfe_guard #(
      .HAS_CRST    (HAS_CRST),
      .CRST_CYCLES (CRST_CYCLES)
   ) u_guard (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (ctrl_q[CB_EN]),
      .ck_mask       (ctrl_q[CB_CKMASK]),
      .seed_fault    (seed_fault),
      .seed_autofix  (seed_autofix),
      .clk_fault     (clk_fault),
      .ctrl_we       (we_ctrl),
      .ctrl_crst_bit (reg_wdata[CB_CRST]),
      .stat_we       (we_stat),
      .stat_seed_bit (reg_wdata[SB_SEERR]),
      .stat_clk_bit  (reg_wdata[SB_CKERR]),
      .flags         (flags),
      .crst_busy     (crst_busy)
   );

   assign fifo_push = ent_valid && ctrl_q[CB_EN] && !flags.seed_now && !crst_busy;

   rngfe_fifo #(
      .DW    (32),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (crst_busy),
      .push  (fifo_push),
      .din   (ent_word),
      .pop   (rd_data),
      .head  (fifo_head),
      .ready (fifo_ready),
      .level (fifo_level)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         unique case (reg_addr)
            OFS_CTRL: begin
               reg_rdata = ctrl_q;
               reg_rdata[CB_CRST] = crst_busy;
            end
            OFS_STAT: begin
               reg_rdata[SB_RDY]   = fifo_ready;
               reg_rdata[SB_SECUR] = flags.seed_now;
               reg_rdata[SB_CKERR] = flags.clk_latched;
               reg_rdata[SB_SEERR] = flags.seed_latched;
            end
            OFS_DATA:  reg_rdata = (fifo_ready && !flags.seed_now) ? fifo_head : '0;
            OFS_NOISE: reg_rdata = REG_W'(noise_q);
            OFS_HTEST: reg_rdata = htest_q;
            default:   reg_rdata = '0;
         endcase
      end
   end

   assert_halt_on_seed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flags.seed_now |=> (fifo_level <= $past(fifo_level)));
   assert_zero_on_seed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && flags.seed_now) |-> (reg_rdata == '0));
   assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
      crst_busy |=> !fifo_ready);
endmodule

// File: tb/rngfe_top_test.sv
module rngfe_top_test;
   import rngfe_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ent_valid = 1'b0;
   logic [31:0] ent_word = '0;
   logic        seed_fault = 1'b0, seed_autofix = 1'b0, clk_fault = 1'b0;

   always #10 clk = ~clk;

   rngfe_top uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ent_valid(ent_valid), .ent_word(ent_word), .seed_fault(seed_fault),
      .seed_autofix(seed_autofix), .clk_fault(clk_fault)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;
   logic [31:0] exp_q[$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic expect_reg(input string req, input logic [4:0] a, input logic [31:0] e);
      logic [31:0] v;
      rd(a, v);
      check(req, v, e);
   endtask

   // driver: feeds a word and records it if the design should keep it
   task automatic feed(input logic [31:0] w, input bit keep);
      ent_valid = 1'b1; ent_word = w;
      @(negedge clk);
      ent_valid = 1'b0;
      if (keep) exp_q.push_back(w);
   endtask

   // monitor side: a data read compared with the oldest expected word
   task automatic read_word(input string req);
      logic [31:0] v;
      logic [31:0] e;
      rd(OFS_DATA, v);
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 32'hxxxx_xxxx;
      check(req, v, e);
   endtask

   task automatic pulse(input int which);
      case (which)
         0: seed_fault = 1'b1;
         1: seed_autofix = 1'b1;
         default: clk_fault = 1'b1;
      endcase
      @(negedge clk);
      seed_fault = 1'b0; seed_autofix = 1'b0; clk_fault = 1'b0;
   endtask

   task automatic crst_wait(input string req, input logic [31:0] ctrl_val);
      logic [31:0] v;
      int n;
      n = 0;
      wr(OFS_CTRL, ctrl_val | 32'h4000_0000);
      wr(OFS_CTRL, ctrl_val);
      do begin
         rd(OFS_CTRL, v);
         if (v[CB_CRST]) n++;
      end while (v[CB_CRST] && n < 100);
      check(req, 32'(n), 32'd16);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      expect_reg("R1 ctrl", OFS_CTRL, 32'h0);
      expect_reg("R1 stat", OFS_STAT, 32'h0);
      expect_reg("R1 data", OFS_DATA, 32'h0);
      expect_reg("R1 noise", OFS_NOISE, 32'h0);
      expect_reg("R1 htest", OFS_HTEST, 32'h0);

      // R3 register widths
      wr(OFS_NOISE, 32'hFFFF_FFFF);
      expect_reg("R3 noise mask", OFS_NOISE, 32'h0003_FFFF);
      wr(OFS_HTEST, 32'hA5A5_1234);
      expect_reg("R3 htest full", OFS_HTEST, 32'hA5A5_1234);

      // R2 control mask, then R8 countdown from the same write pair
      wr(OFS_CTRL, 32'hFFFF_FFFF);
      expect_reg("R2 ctrl mask", OFS_CTRL, 32'h43FF_FF24);
      crst_wait("R8 busy cycles", 32'h0);
      expect_reg("R2 ctrl cleared", OFS_CTRL, 32'h0);

      // R5 disabled: word refused
      feed(32'hDEAD_0000, 1'b0);
      expect_reg("R5 no ready when disabled", OFS_STAT, 32'h0);

      // R4 fill and drain
      wr(OFS_CTRL, 32'h4);
      feed(32'h1111_0001, 1'b1);
      feed(32'h2222_0002, 1'b1);
      feed(32'h3333_0003, 1'b1);
      expect_reg("R4 not ready at three", OFS_STAT, 32'h0);
      feed(32'h4444_0004, 1'b1);
      expect_reg("R4 ready at four", OFS_STAT, 32'h1);
      feed(32'h5555_0005, 1'b0); // R5 refused while ready
      for (int i = 0; i < 4; i++) read_word("R4/R5 data order");
      expect_reg("R4 ready clears", OFS_STAT, 32'h0);
      expect_reg("R4 empty read zero", OFS_DATA, 32'h0);

      // second pattern, then late seed fault
      feed(32'h0000_0000, 1'b1);
      feed(32'hFFFF_FFFF, 1'b1);
      feed(32'h8000_0001, 1'b1);
      feed(32'h7FFF_FFFE, 1'b1);
      read_word("R4 zero word");
      read_word("R4 ones word");
      pulse(0);
      expect_reg("R6 seed flags", OFS_STAT, 32'h45);
      expect_reg("R7 late zero a", OFS_DATA, 32'h0);
      void'(exp_q.pop_front());
      expect_reg("R7 late zero b", OFS_DATA, 32'h0);
      void'(exp_q.pop_front());
      expect_reg("R7 buffer drained", OFS_STAT, 32'h44);
      for (int i = 0; i < 4; i++) feed(32'hBAD0_0000 + 32'(i), 1'b0);
      expect_reg("R6 no intake on fault", OFS_STAT, 32'h44);

      // R8 recovery
      crst_wait("R8 busy cycles after fault", 32'h4);
      expect_reg("R8 seed flags cleared", OFS_STAT, 32'h0);
      feed(32'hA000_0001, 1'b1);
      feed(32'hA000_0002, 1'b1);
      feed(32'hA000_0003, 1'b1);
      feed(32'hA000_0004, 1'b1);
      expect_reg("R8 ready before flush", OFS_STAT, 32'h1);
      crst_wait("R8 busy cycles full buffer", 32'h4);
      exp_q.delete();
      expect_reg("R8 flushed", OFS_STAT, 32'h0);
      feed(32'hC000_0001, 1'b1);
      feed(32'hC000_0002, 1'b1);
      feed(32'hC000_0003, 1'b1);
      feed(32'hC000_0004, 1'b1);
      for (int i = 0; i < 4; i++) read_word("R8 fresh data");

      // R9 self-repaired fault
      pulse(1);
      expect_reg("R9 latched only", OFS_STAT, 32'h40);
      wr(OFS_STAT, 32'hFFFF_FFFF);
      expect_reg("R9 write one ignored", OFS_STAT, 32'h40);
      wr(OFS_STAT, 32'h0);
      expect_reg("R9 write zero clears", OFS_STAT, 32'h0);

      // R10 clock fault
      pulse(2);
      expect_reg("R10 clock flag", OFS_STAT, 32'h20);
      wr(OFS_STAT, 32'hFFFF_FFDF);
      expect_reg("R10 clock flag cleared", OFS_STAT, 32'h0);
      wr(OFS_CTRL, 32'h24);
      pulse(2);
      expect_reg("R10 masked", OFS_STAT, 32'h0);

      finish_run();
   end
endmodule